// File: doc/BRIEF.md
# Dispatch Group Former

The block sits between an in-order queue of decoded instructions and the issue queues of a superscalar core. In each cycle it looks at a window of up to six entries at the head of the queue and packs as many of them as the grouping rules allow into one dispatch group. The rules cover three things: how many branch and non-branch instructions a group may hold, pairs of vector-unit instructions that may not share a cycle, and a write-back port conflict on the first vector pipe that depends on time. The group goes to a registered six-slot output that has one valid bit per slot. The block tells the queue how many head entries it consumed.

The input side offers entries in program order with a contiguous valid mask. The block answers with `in_take`, the number of entries popped on the coming clock edge. The output side is a registered group, offered with `out_valid`, and the consumer accepts it with `out_ready`. A group counts as issued in the cycle in which it is loaded into the output register. Every timing rule below counts in those issue cycles. The block does not rename registers, track operand dependences or execute anything.

Each descriptor is `TAGW + 7` bits wide. Bit `TAGW+6` is the branch flag. Bits `TAGW+5..TAGW+3` are the pipe class: 0 fixed-point, 1 load/store, 2 vector pipe one (V1), 3 vector pipe two (V2), 4 condition unit, 5 branch unit. Bit `TAGW+2` is the floating-point flag, bit `TAGW+1` is the simple-vector (XS) flag and bit `TAGW` is the four-single-precision-input flag. The low `TAGW` bits are an opaque tag that is carried through unchanged.

Top module: `dispatch_group_former`

## Requirements
- R1: After synchronous active-high reset, `out_valid` and every `out_slot_valid` bit are 0, and the hazard history is clear, so an XS instruction for V1 presented first after reset is taken.
- R2: A group never holds more than `NONBR_MAX` (4) instructions whose branch flag (bit `TAGW+6`) is 0.
- R3: A group never holds more than `BR_MAX` (2) branches, and the second branch is always the last valid slot of its group.
- R4: A single branch does not close a group: instructions after it in program order join the same group while the other limits allow.
- R5: The taken entries are the longest legal prefix of the window. The slots are filled in program order from slot 0, `in_take` equals the number of valid slots of the group loaded at the next edge, and each valid slot carries its input descriptor unchanged. Unused slots read as zero.
- R6: A group never holds both a V1 instruction (pipe 2) that has the four-single-precision flag set and a V2 instruction (pipe 3) that has the floating-point flag set. Whichever of the two comes later in program order waits.
- R7: A V1 instruction with the XS flag set is not issued in the cycle exactly `HAZ_GAP` (5) issue cycles after a cycle that issued a V1 instruction with the floating-point flag set. It may issue 4 or 6 cycles after.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output group is held unchanged and `in_take` is 0.
- R9: When no input entry is valid and the output register may load, the next output is an empty group (`out_valid` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | WIN (6) | Valid mask of the queue-head window, contiguous from bit 0 |
| in_desc | input | WIN*DW (90) | Window descriptors, entry i at bits i*DW upward |
| in_take | output | 3 | Number of head entries consumed at the next clock edge |
| out_ready | input | 1 | Downstream accepts the offered group |
| out_valid | output | 1 | The output group holds at least one instruction |
| out_slot_valid | output | WIN (6) | Per-slot valid bits of the output group |
| out_desc | output | WIN*DW (90) | Descriptors of the output group, slot i at bits i*DW upward |

## Verification
The vector-pipe pairing check and the write-back timer can both stop a group in the same cycle, and either of them can also meet the branch or non-branch caps there. The random phase mixes XS, floating-point and four-input V1 entries with floating-point V2 entries and branches. It uses random window sizes and random downstream stalls, so the timer often expires on a cycle where a pairing conflict or a full cap also applies. A bench model that keeps issue times by cycle number judges each cycle by the first entry that breaks any rule. Directed sequences pin the timer at distances 4, 5 and 6 and test each pairing order on its own.

// File: rtl/dgf_pkg.sv
`timescale 1ns/1ps
package dgf_pkg;

  localparam int ATTR_W = 7;

  typedef enum logic [2:0] {
    PIPE_FX  = 3'd0,
    PIPE_LS  = 3'd1,
    PIPE_VS1 = 3'd2,
    PIPE_VS2 = 3'd3,
    PIPE_CR  = 3'd4,
    PIPE_BR  = 3'd5
  } pipe_e;

  typedef struct packed {
    logic  br;
    pipe_e pipe;
    logic  fp;
    logic  xs;
    logic  sp4;
  } attr_t;

  // floating-point work headed for the first vector pipe: arms the port timer
  function automatic logic vs1_vfp(attr_t a);
    return (a.pipe == PIPE_VS1) && a.fp;
  endfunction

  // simple-vector work on the first vector pipe: blocked by the timer
  function automatic logic vs1_xs(attr_t a);
    return (a.pipe == PIPE_VS1) && a.xs;
  endfunction

  function automatic logic vs1_sp4(attr_t a);
    return (a.pipe == PIPE_VS1) && a.sp4;
  endfunction

  function automatic logic vs2_fp(attr_t a);
    return (a.pipe == PIPE_VS2) && a.fp;
  endfunction

  // true when a joins a group that already holds its forbidden partner
  function automatic logic pair_clash(attr_t a, logic have_sp4, logic have_v2fp);
    return (vs2_fp(a) && have_sp4) || (vs1_sp4(a) && have_v2fp);
  endfunction

endpackage

// File: rtl/dgf_packer.sv
`timescale 1ns/1ps
module dgf_packer
  import dgf_pkg::*;
#(
  parameter int NONBR_MAX = 4,
  parameter int BR_MAX    = 2,
  localparam int WIN      = NONBR_MAX + BR_MAX,
  localparam int CW       = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0]        win_valid,
  input  logic [WIN*ATTR_W-1:0] win_attr,
  input  logic                  xs_block,
  output logic [WIN-1:0]        accept,
  output logic [CW-1:0]         take,
  output logic                  vfp_hit
);

  always_comb begin : pack_walk
    int    nb;
    int    bc;
    logic  halt;
    logic  seen_sp4;
    logic  seen_v2fp;
    logic  ok;
    attr_t a;
    nb        = 0;
    bc        = 0;
    halt      = 1'b0;
    seen_sp4  = 1'b0;
    seen_v2fp = 1'b0;
    accept    = '0;
    take      = '0;
    vfp_hit   = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      a  = attr_t'(win_attr[i*ATTR_W +: ATTR_W]);
      ok = !halt && win_valid[i];
      if (a.br) ok = ok && (bc < BR_MAX);
      else      ok = ok && (nb < NONBR_MAX);
      ok = ok && !pair_clash(a, seen_sp4, seen_v2fp);
      ok = ok && !(xs_block && vs1_xs(a));
      if (ok) begin
        accept[i] = 1'b1;
        take      = take + CW'(1);
        if (a.br) bc = bc + 1;
        else      nb = nb + 1;
        seen_sp4  = seen_sp4  | vs1_sp4(a);
        seen_v2fp = seen_v2fp | vs2_fp(a);
        vfp_hit   = vfp_hit   | vs1_vfp(a);
        if (a.br && (bc == BR_MAX)) halt = 1'b1;
      end else begin
        halt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dgf_hazard.sv
`timescale 1ns/1ps
module dgf_hazard #(
  parameter int GAP = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic vfp_issue,
  output logic xs_block
);

  generate
    if (GAP == 1) begin : g_one
      logic hit_q;
      always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= vfp_issue;
      end
      assign xs_block = hit_q;
    end else begin : g_chain
      logic [GAP-1:0] age_q;
      always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else     age_q <= {age_q[GAP-2:0], vfp_issue};
      end
      assign xs_block = age_q[GAP-1];
    end
  endgenerate

endmodule

// File: rtl/dgf_outreg.sv
`timescale 1ns/1ps
module dgf_outreg #(
  parameter int WIN = 6,
  parameter int DW  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WIN-1:0]    accept,
  input  logic [WIN*DW-1:0] win_desc,
  output logic [WIN-1:0]    slot_valid,
  output logic [WIN*DW-1:0] slot_desc
);

  generate
    for (genvar s = 0; s < WIN; s++) begin : g_slot
      logic          v_q;
      logic [DW-1:0] d_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (load) begin
          v_q <= accept[s];
          d_q <= accept[s] ? win_desc[s*DW +: DW] : '0;
        end
      end
      assign slot_valid[s]         = v_q;
      assign slot_desc[s*DW +: DW] = d_q;
    end
  endgenerate

endmodule

// File: rtl/dispatch_group_former.sv
`timescale 1ns/1ps
module dispatch_group_former
  import dgf_pkg::*;
#(
  parameter int NONBR_MAX = 4,
  parameter int BR_MAX    = 2,
  parameter int TAGW      = 8,
  parameter int HAZ_GAP   = 5,
  localparam int WIN      = NONBR_MAX + BR_MAX,
  localparam int DW       = TAGW + ATTR_W,
  localparam int CW       = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN-1:0]    in_valid,
  input  logic [WIN*DW-1:0] in_desc,
  output logic [CW-1:0]     in_take,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WIN-1:0]    out_slot_valid,
  output logic [WIN*DW-1:0] out_desc
);

  logic [WIN*ATTR_W-1:0] win_attr;
  logic [WIN-1:0]        accept;
  logic [CW-1:0]         take;
  logic                  vfp_hit;
  logic                  xs_block;
  logic                  load;
  logic                  vfp_issue;

  generate
    for (genvar g = 0; g < WIN; g++) begin : g_attr
      assign win_attr[g*ATTR_W +: ATTR_W] = in_desc[g*DW + TAGW +: ATTR_W];
    end
  endgenerate

  assign out_valid = |out_slot_valid;
  assign load      = !out_valid || out_ready;
  assign in_take   = load ? take : '0;
  assign vfp_issue = load && vfp_hit;

  dgf_packer #(
    .NONBR_MAX (NONBR_MAX),
    .BR_MAX    (BR_MAX)
  ) u_pack (
    .win_valid (in_valid),
    .win_attr  (win_attr),
    .xs_block  (xs_block),
    .accept    (accept),
    .take      (take),
    .vfp_hit   (vfp_hit)
  );

  dgf_hazard #(
    .GAP (HAZ_GAP)
  ) u_haz (
    .clk       (clk),
    .rst       (rst),
    .vfp_issue (vfp_issue),
    .xs_block  (xs_block)
  );

  dgf_outreg #(
    .WIN (WIN),
    .DW  (DW)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .accept     (accept),
    .win_desc   (in_desc),
    .slot_valid (out_slot_valid),
    .slot_desc  (out_desc)
  );

endmodule

// File: rtl/dgf_checker.sv
`timescale 1ns/1ps
module dgf_checker
  import dgf_pkg::*;
#(
  parameter int NONBR_MAX = 4,
  parameter int BR_MAX    = 2,
  parameter int TAGW      = 8,
  parameter int HAZ_GAP   = 5,
  localparam int WIN      = NONBR_MAX + BR_MAX,
  localparam int DW       = TAGW + ATTR_W,
  localparam int CW       = $clog2(WIN + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [WIN-1:0]    in_valid,
  input logic [CW-1:0]     in_take,
  input logic              out_ready,
  input logic              out_valid,
  input logic [WIN-1:0]    out_slot_valid,
  input logic [WIN*DW-1:0] out_desc,
  input logic              xs_block
);

  int   nbc;
  int   brc;
  logic br_not_last;
  logic any_sp4;
  logic any_v2fp;
  logic any_vfp;
  logic any_xs;
  logic can_load;
  logic rst_q;
  logic loaded_q;
  logic [HAZ_GAP:1] seen_q;

  assign can_load = !out_valid || out_ready;

  always_comb begin : slot_scan
    attr_t a;
    int    br_seen;
    nbc         = 0;
    brc         = 0;
    br_seen     = 0;
    br_not_last = 1'b0;
    any_sp4     = 1'b0;
    any_v2fp    = 1'b0;
    any_vfp     = 1'b0;
    any_xs      = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      a = attr_t'(out_desc[i*DW + TAGW +: ATTR_W]);
      if (out_slot_valid[i]) begin
        if (br_seen == BR_MAX) br_not_last = 1'b1;
        if (a.br) begin
          brc     = brc + 1;
          br_seen = br_seen + 1;
        end else begin
          nbc = nbc + 1;
        end
        any_sp4  = any_sp4  | vs1_sp4(a);
        any_v2fp = any_v2fp | vs2_fp(a);
        any_vfp  = any_vfp  | vs1_vfp(a);
        any_xs   = any_xs   | vs1_xs(a);
      end
    end
  end

  // own record of floating-point V1 issues, seen from the output side
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      loaded_q <= 1'b0;
      seen_q   <= '0;
    end else begin
      loaded_q <= can_load;
      seen_q   <= {seen_q[HAZ_GAP-1:1], loaded_q && any_vfp};
    end
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (out_slot_valid == '0) && !out_valid);

  a_r2_nonbr_cap: assert property (@(posedge clk) disable iff (rst)
    nbc <= NONBR_MAX);

  a_r3_br_cap: assert property (@(posedge clk) disable iff (rst)
    brc <= BR_MAX);

  a_r3_second_br_last: assert property (@(posedge clk) disable iff (rst)
    !br_not_last);

  a_r5_prefix: assert property (@(posedge clk) disable iff (rst)
    (out_slot_valid & (out_slot_valid + WIN'(1))) == '0);

  a_r5_take_matches: assert property (@(posedge clk) disable iff (rst)
    can_load |=> $countones(out_slot_valid) == int'($past(in_take)));

  a_r6_no_pair: assert property (@(posedge clk) disable iff (rst)
    !(any_sp4 && any_v2fp));

  a_r7_timer_agrees: assert property (@(posedge clk) disable iff (rst)
    xs_block == seen_q[HAZ_GAP-1]);

  a_r7_xs_gap: assert property (@(posedge clk) disable iff (rst)
    (loaded_q && any_xs) |-> !seen_q[HAZ_GAP]);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_slot_valid) && $stable(out_desc));

  a_r8_no_pop: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> in_take == '0);

  a_r9_empty_window: assert property (@(posedge clk) disable iff (rst)
    (in_valid == '0 && can_load) |=> !out_valid);

endmodule

bind dispatch_group_former dgf_checker #(
  .NONBR_MAX (NONBR_MAX),
  .BR_MAX    (BR_MAX),
  .TAGW      (TAGW),
  .HAZ_GAP   (HAZ_GAP)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_take        (in_take),
  .out_ready      (out_ready),
  .out_valid      (out_valid),
  .out_slot_valid (out_slot_valid),
  .out_desc       (out_desc),
  .xs_block       (xs_block)
);

// File: tb/dispatch_group_former_test.sv
`timescale 1ns/1ps
module dispatch_group_former_test;
  import dgf_pkg::*;

  localparam int NB   = 4;
  localparam int BRM  = 2;
  localparam int TAGW = 8;
  localparam int GAP  = 5;
  localparam int WIN  = NB + BRM;
  localparam int DW   = TAGW + ATTR_W;
  localparam int CW   = $clog2(WIN + 1);

  logic              clk;
  logic              rst;
  logic [WIN-1:0]    in_valid;
  logic [WIN*DW-1:0] in_desc;
  logic [CW-1:0]     in_take;
  logic              out_ready;
  logic              out_valid;
  logic [WIN-1:0]    out_slot_valid;
  logic [WIN*DW-1:0] out_desc;

  dispatch_group_former #(
    .NONBR_MAX (NB),
    .BR_MAX    (BRM),
    .TAGW      (TAGW),
    .HAZ_GAP   (GAP)
  ) uut (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_desc        (in_desc),
    .in_take        (in_take),
    .out_ready      (out_ready),
    .out_valid      (out_valid),
    .out_slot_valid (out_slot_valid),
    .out_desc       (out_desc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [DW-1:0]     q [0:16383];
  bit                vfp_at [0:8191];
  int                qn, head, cyc, last_take;
  int                nchk, nfail;
  logic [WIN-1:0]    m_sv;
  logic [WIN*DW-1:0] m_desc;
  logic [7:0]        tagc;

  task automatic chk(bit ok, string req, string act, string exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %s expected %s (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] mk(bit br, logic [2:0] pipe, bit fp, bit xs, bit sp4, logic [7:0] tag);
    return {br, pipe, fp, xs, sp4, tag};
  endfunction

  task automatic push(bit br, logic [2:0] pipe, bit fp, bit xs, bit sp4);
    tagc  = tagc + 8'd1;
    q[qn] = mk(br, pipe, fp, xs, sp4, tagc);
    qn++;
  endtask

  // bench restatement of the grouping rules: length of the legal prefix
  function automatic int legal_len(int avail, bit timer_hot);
    int  nonbr = 0;
    int  brs   = 0;
    bit  got_sp4 = 0;
    bit  got_v2fp = 0;
    for (int k = 0; k < avail; k++) begin
      logic [DW-1:0] d = q[head + k];
      bit   isbr = d[DW-1];
      int   pp   = int'(d[DW-2:DW-4]);
      bit   f    = d[DW-5];
      bit   x    = d[DW-6];
      bit   s    = d[DW-7];
      bit   v1s4 = (pp == 2) && s;
      bit   v2f  = (pp == 3) && f;
      if (isbr ? (brs >= BRM) : (nonbr >= NB)) return k;
      if ((v2f && got_sp4) || (v1s4 && got_v2fp)) return k;
      if ((pp == 2) && x && timer_hot) return k;
      if (isbr) brs++; else nonbr++;
      got_sp4  = got_sp4 | v1s4;
      got_v2fp = got_v2fp | v2f;
      if (isbr && brs == BRM) return k + 1;
    end
    return avail;
  endfunction

  task automatic step(int lim, bit rdy);
    int  avail;
    int  et;
    bit  ld;
    bit  hot;
    bit  any_vfp;
    @(negedge clk);
    avail = (qn - head < lim) ? (qn - head) : lim;
    in_valid = '0;
    in_desc  = '0;
    for (int i = 0; i < avail; i++) begin
      in_valid[i]            = 1'b1;
      in_desc[i*DW +: DW]    = q[head + i];
    end
    out_ready = rdy;
    #1;
    ld  = (m_sv == '0) || rdy;
    hot = (cyc >= GAP) && vfp_at[cyc - GAP];
    et  = ld ? legal_len(avail, hot) : 0;
    last_take = int'(in_take);
    chk(int'(in_take) == et, "R5 take count", $sformatf("%0d", in_take), $sformatf("%0d", et));
    @(posedge clk);
    #1;
    any_vfp = 0;
    if (ld) begin
      m_sv   = '0;
      m_desc = '0;
      for (int i = 0; i < et; i++) begin
        m_sv[i]              = 1'b1;
        m_desc[i*DW +: DW]   = q[head + i];
        if (q[head + i][DW-2:DW-4] == 3'd2 && q[head + i][DW-5]) any_vfp = 1;
      end
    end
    vfp_at[cyc] = any_vfp;
    head = head + et;
    cyc++;
    chk(out_slot_valid == m_sv && out_valid == (m_sv != '0), "R5 slot valid",
        $sformatf("%b/%b", out_slot_valid, out_valid), $sformatf("%b/%b", m_sv, m_sv != '0));
    chk(out_desc == m_desc, "R5 slot contents", $sformatf("%h", out_desc), $sformatf("%h", m_desc));
  endtask

  task automatic expect_take(int n, string req);
    chk(last_take == n, req, $sformatf("take %0d", last_take), $sformatf("take %0d", n));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    nchk = 0; nfail = 0; qn = 0; head = 0; cyc = 0; tagc = 8'd0;
    m_sv = '0; m_desc = '0;
    for (int i = 0; i < 8192; i++) vfp_at[i] = 0;
    rst = 1'b1; in_valid = '0; in_desc = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_slot_valid == '0, "R1 reset state",
        $sformatf("%b/%b", out_valid, out_slot_valid), "0/000000");
    rst = 1'b0;

    // R1: history clear, XS on V1 goes out at once
    push(0, PIPE_VS1, 0, 1, 0);
    step(6, 1); expect_take(1, "R1 xs after reset");

    // R2: four non-branch cap
    repeat (6) push(0, PIPE_FX, 0, 0, 0);
    step(6, 1); expect_take(4, "R2 nonbranch cap");
    step(6, 1); expect_take(2, "R2 remainder");

    // R4: lone branch keeps the group open
    push(1, PIPE_BR, 0, 0, 0);
    repeat (5) push(0, PIPE_LS, 0, 0, 0);
    step(6, 1); expect_take(5, "R4 branch then four");
    chk(out_slot_valid == 6'b011111, "R4 slots", $sformatf("%b", out_slot_valid), "011111");
    step(6, 1); expect_take(1, "R4 remainder");

    // R3: second branch closes the group
    push(0, PIPE_FX, 0, 0, 0); push(1, PIPE_BR, 0, 0, 0); push(0, PIPE_FX, 0, 0, 0);
    push(1, PIPE_BR, 0, 0, 0); push(0, PIPE_FX, 0, 0, 0); push(0, PIPE_FX, 0, 0, 0);
    step(6, 1); expect_take(4, "R3 second branch last");
    step(6, 1); expect_take(2, "R3 remainder");
    push(1, PIPE_BR, 0, 0, 0); push(1, PIPE_CR, 0, 0, 0); push(0, PIPE_FX, 0, 0, 0);
    step(6, 1); expect_take(2, "R3 two leading branches");
    step(6, 1); expect_take(1, "R3 remainder");

    // R6: pairing in both orders, and the harmless neighbour
    push(0, PIPE_VS1, 0, 0, 1); push(0, PIPE_VS2, 1, 0, 0);
    step(6, 1); expect_take(1, "R6 four-input first");
    step(6, 1); expect_take(1, "R6 remainder");
    push(0, PIPE_VS2, 1, 0, 0); push(0, PIPE_VS1, 0, 0, 1);
    step(6, 1); expect_take(1, "R6 fp V2 first");
    step(6, 1); expect_take(1, "R6 remainder");
    push(0, PIPE_VS1, 0, 0, 1); push(0, PIPE_VS2, 0, 0, 0);
    step(6, 1); expect_take(2, "R6 non-fp V2 allowed");

    // R7: distance 4 is free
    repeat (6) step(0, 1);
    push(0, PIPE_VS1, 1, 0, 0);
    step(1, 1); expect_take(1, "R7 arm timer");
    push(0, PIPE_VS1, 0, 1, 0);
    repeat (3) step(0, 1);
    step(1, 1); expect_take(1, "R7 distance 4");
    // distance 5 blocked, 6 free
    repeat (6) step(0, 1);
    push(0, PIPE_VS1, 1, 0, 0);
    step(1, 1); expect_take(1, "R7 arm timer");
    push(0, PIPE_VS1, 0, 1, 0);
    repeat (4) step(0, 1);
    step(1, 1); expect_take(0, "R7 distance 5 blocked");
    step(1, 1); expect_take(1, "R7 distance 6");

    // R8: stall holds the group
    repeat (3) push(0, PIPE_FX, 0, 0, 0);
    step(1, 1); expect_take(1, "R8 fill");
    step(6, 0); expect_take(0, "R8 stalled no pop");
    chk(out_slot_valid == 6'b000001, "R8 held", $sformatf("%b", out_slot_valid), "000001");
    step(6, 0); expect_take(0, "R8 still stalled");
    step(6, 1); expect_take(2, "R8 release");

    // R9: empty window gives an empty group
    step(0, 1);
    chk(out_valid == 1'b0, "R9 empty group", $sformatf("%b", out_valid), "0");
    expect_take(0, "R9 nothing popped");

    // random phase
    for (int n = 0; n < 2000; n++) begin
      while (qn - head < 8) begin
        bit br = ($urandom % 4) == 0;
        logic [2:0] pp = br ? 3'(PIPE_BR) : 3'($urandom % 5);
        if (!br && ($urandom % 3) == 0) pp = 3'(PIPE_VS1);
        push(br, pp, ($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0);
      end
      step(int'($urandom % 7), ($urandom % 4) != 0);
    end

    summary();
    $finish;
  end

endmodule